// File: doc/BRIEF.md
# Instruction Fetch Line-Fill Buffer Controller

This block runs one 16-byte line buffer that sits next to a direct-mapped instruction cache data array. When a cacheable fetch misses both the array and the buffer, the block asks the bus for a burst of four longwords. The burst starts with the longword the processor needs. That longword goes straight to the processor, and the other three fill the buffer. A recency flag records whether the buffer or the array entry at the same index was used more recently. On the next refill, the old buffer line is written into the array only if it is complete, still the more recent copy, and was loaded as cacheable.

Two control bits choose how each fetch is handled:
- With caching off, every fetch goes to the bus as a single access.
- With caching on and buffering off, noncacheable fetches also go to the bus as single accesses.
- With caching on and buffering on, noncacheable fetches are loaded into the buffer as full line bursts. Later fetches can hit those lines, but such lines never reach the array.

The tag lookup, the array storage and bus arbitration sit outside the block. The processor keeps `fch_valid` and `fch_addr` steady until `fch_ready` is high.

Top module: `ifetch_fill_ctrl`

## Requirements
- R1: A fetch that starts a refill does three things. It marks the buffer as the more recent copy, clears all four longword valid bits, and raises `bus_req` for exactly one cycle on the next clock with `bus_size` = 2 (line) and `bus_addr` set to the requested longword. Beats then arrive in wrapping order: requested longword, +1, +2, +3, modulo 4.
- R2: When a fetch is served from the array and its index matches the buffer line's index, the recency flag is cleared. The index is address bits [12:4], or bits [11:4] when `SPLIT_IDX`=1. A fetch served from the array at a different index leaves the flag set.
- R3: The buffer's old line is offered to the array only in the cycle a refill is accepted. In that cycle `ary_we` is high, `ary_wline` carries address bits [31:4] of the old line, and `ary_wdata` carries the old line with longword n at bits [32n+31:32n]. This happens only if all four longwords are valid, the recency flag is set and the line was cacheable.
- R4: With `cfg_cache_en`=0, every fetch is a single bus access returned with source code 0. Array hits and buffer contents are ignored.
- R5: With `cfg_cache_en`=1, `cfg_buf_en`=0 and `fch_cacheable`=0, the fetch is a single bus access, even when the buffer holds that line.
- R6: With both control bits at 1 and `fch_cacheable`=0, a miss loads the line into the buffer through a line burst, and later fetches to that line are served from the buffer.
- R7: A single bus access uses `bus_size` 0 (word) when `fch_addr[1]` is 1, and `bus_size` 1 (longword) when `fch_addr[1]` is 0.
- R8: The buffer serves a fetch only when the line address matches and that longword's valid bit is set. The requested longword of a refill is returned with `fch_ready` in the cycle its beat arrives, which is 1 + bus latency cycles after the fetch is presented on an idle block.
- R9: A line loaded as noncacheable is never written to the array, even when it is complete at the next miss.
- R10: When a cacheable fetch hits both the array and the buffer, the buffer serves it if the recency flag is set, and the array serves it otherwise.
- R11: `fch_src` reports where the returned data came from: 0 for the bus, 1 for the array, 2 for the buffer. `fch_ready` is never high without `fch_valid`.
- R12: During reset, `bus_req`, `ary_we` and `fch_ready` are 0 and the buffer is empty, so the first refill writes nothing to the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cache_en | input | 1 | Cache enable |
| cfg_buf_en | input | 1 | Buffering of noncacheable line fetches |
| fch_valid | input | 1 | Fetch request, held until ready |
| fch_addr | input | ADDR_W | Fetch byte address |
| fch_cacheable | input | 1 | Fetch attribute: cacheable |
| fch_ready | output | 1 | Fetch data returned this cycle |
| fch_rdata | output | 32 | Fetch data |
| fch_src | output | 2 | Data source: 0 bus, 1 array, 2 buffer |
| ary_hit | input | 1 | Tag lookup hit for the fetch address |
| ary_rdata | input | 32 | Array data for the fetch address |
| ary_we | output | 1 | Write the buffer line into the array |
| ary_wline | output | ADDR_W-4 | Line address of the written line |
| ary_wdata | output | 128 | Line data being written |
| bus_req | output | 1 | One-cycle bus request |
| bus_addr | output | ADDR_W | Request address |
| bus_size | output | 2 | 0 word, 1 longword, 2 line |
| bus_rvalid | input | 1 | Read beat valid |
| bus_rdata | input | 32 | Read beat data |

## Verification
The bench builds the block with a 32-bit address and `SPLIT_IDX`=0, so the recency index is bits [12:4]. With that index, 0x2200 and 0x200 fall on the same slot but carry different line addresses, which makes the recency-clearing case reachable. The bus model replies after two cycles. At that latency, a fetch that follows a critical-word return still finds the refill in progress, so both the early buffer hits and the stall of a bus-only fetch behind an active burst are exercised.

// File: rtl/ifill_pkg.sv
package ifill_pkg;
  localparam int LINE_WORDS = 4;
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int OFS_W      = WSEL_W + 2;
  localparam int DATA_W     = 32;
  localparam int LINE_BITS  = LINE_WORDS * DATA_W;

  typedef enum logic [1:0] {SZ_WORD = 2'd0, SZ_LONG = 2'd1, SZ_LINE = 2'd2} bsize_e;
  typedef enum logic [1:0] {SRC_BUS = 2'd0, SRC_ARRAY = 2'd1, SRC_BUF = 2'd2} src_e;
  typedef enum logic [1:0] {PATH_DIRECT, PATH_CACHE, PATH_BUFONLY} path_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LINE, ST_SINGLE} seq_e;

  // Longword slot written by beat n of a wrapping burst.
  function automatic logic [WSEL_W-1:0] beat_slot(input logic [WSEL_W-1:0] first,
                                                  input logic [WSEL_W-1:0] n);
    return first + n;
  endfunction

  // Single accesses: odd halfword target takes a word access.
  function automatic bsize_e single_size(input logic half_sel);
    return half_sel ? SZ_WORD : SZ_LONG;
  endfunction

  function automatic path_e pick_path(input logic cen, input logic ben, input logic cacheable);
    if (!cen)           return PATH_DIRECT;
    else if (cacheable) return PATH_CACHE;
    else if (ben)       return PATH_BUFONLY;
    else                return PATH_DIRECT;
  endfunction
endpackage

// File: rtl/ifill_path_dec.sv
module ifill_path_dec
  import ifill_pkg::*;
(
  input  logic   cache_en,
  input  logic   buf_en,
  input  logic   cacheable,
  input  logic   half_sel,
  output path_e  path,
  output bsize_e one_size
);
  assign path     = pick_path(cache_en, buf_en, cacheable);
  assign one_size = single_size(half_sel);
endmodule

// File: rtl/ifill_buf_store.sv
module ifill_buf_store
  import ifill_pkg::*;
#(
  parameter int LINE_W = 28
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [LINE_W-1:0]     load_line,
  input  logic                  load_nc,
  input  logic                  beat_we,
  input  logic [WSEL_W-1:0]     beat_word,
  input  logic [DATA_W-1:0]     beat_data,
  input  logic                  mru_clr,
  input  logic [LINE_W-1:0]     look_line,
  input  logic [WSEL_W-1:0]     look_word,
  output logic                  look_hit,
  output logic [DATA_W-1:0]     look_data,
  output logic [LINE_W-1:0]     held_line,
  output logic                  held_mru,
  output logic                  held_nc,
  output logic                  held_loaded,
  output logic                  held_full,
  output logic [LINE_WORDS-1:0] held_vld,
  output logic [LINE_BITS-1:0]  held_flat
);
  logic [LINE_W-1:0] line_q;
  logic              mru_q, nc_q, loaded_q;

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_slot
    logic              slot_v;
    logic [DATA_W-1:0] slot_d;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_v <= 1'b0;
        slot_d <= '0;
      end else if (load) begin
        slot_v <= 1'b0;
      end else if (beat_we && beat_word == WSEL_W'(w)) begin
        slot_v <= 1'b1;
        slot_d <= beat_data;
      end
    end
    assign held_vld[w]                    = slot_v;
    assign held_flat[w*DATA_W +: DATA_W]  = slot_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= '0;
      mru_q    <= 1'b0;
      nc_q     <= 1'b0;
      loaded_q <= 1'b0;
    end else if (load) begin
      line_q   <= load_line;
      mru_q    <= 1'b1;
      nc_q     <= load_nc;
      loaded_q <= 1'b1;
    end else if (mru_clr) begin
      mru_q    <= 1'b0;
    end
  end

  assign held_line   = line_q;
  assign held_mru    = mru_q;
  assign held_nc     = nc_q;
  assign held_loaded = loaded_q;
  assign held_full   = &held_vld;
  assign look_hit    = loaded_q && (line_q == look_line) && held_vld[look_word];
  assign look_data   = held_flat[look_word*DATA_W +: DATA_W];
endmodule

// File: rtl/ifill_bus_seq.sv
module ifill_bus_seq
  import ifill_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_line,
  input  logic              go_single,
  input  logic [ADDR_W-1:0] go_addr,
  input  bsize_e            go_size,
  input  logic              bus_rvalid,
  output seq_e              st,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output bsize_e            bus_size,
  output logic              beat_we,
  output logic [WSEL_W-1:0] beat_word,
  output logic              beat_first,
  output logic              single_done
);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  seq_e              st_q;
  logic              req_q;
  logic [ADDR_W-1:0] addr_q;
  bsize_e            size_q;
  logic [WSEL_W-1:0] first_q, cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      req_q   <= 1'b0;
      addr_q  <= '0;
      size_q  <= SZ_LONG;
      first_q <= '0;
      cnt_q   <= '0;
    end else begin
      req_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (go_line) begin
            st_q    <= ST_LINE;
            req_q   <= 1'b1;
            addr_q  <= {go_addr[ADDR_W-1:2], 2'b00};
            size_q  <= SZ_LINE;
            first_q <= go_addr[OFS_W-1:2];
            cnt_q   <= '0;
          end else if (go_single) begin
            st_q   <= ST_SINGLE;
            req_q  <= 1'b1;
            addr_q <= go_addr;
            size_q <= go_size;
          end
        end
        ST_LINE: begin
          if (bus_rvalid) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BEAT) st_q <= ST_IDLE;
          end
        end
        ST_SINGLE: begin
          if (bus_rvalid) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st          = st_q;
  assign bus_req     = req_q;
  assign bus_addr    = addr_q;
  assign bus_size    = size_q;
  assign beat_we     = (st_q == ST_LINE) && bus_rvalid;
  assign beat_word   = beat_slot(first_q, cnt_q);
  assign beat_first  = beat_we && (cnt_q == '0);
  assign single_done = (st_q == ST_SINGLE) && bus_rvalid;
endmodule

// File: rtl/ifetch_fill_ctrl.sv
module ifetch_fill_ctrl
  import ifill_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit SPLIT_IDX = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_cache_en,
  input  logic                         cfg_buf_en,
  input  logic                         fch_valid,
  input  logic [ADDR_W-1:0]            fch_addr,
  input  logic                         fch_cacheable,
  output logic                         fch_ready,
  output logic [31:0]                  fch_rdata,
  output logic [1:0]                   fch_src,
  input  logic                         ary_hit,
  input  logic [31:0]                  ary_rdata,
  output logic                         ary_we,
  output logic [ADDR_W-5:0]            ary_wline,
  output logic [127:0]                 ary_wdata,
  output logic                         bus_req,
  output logic [ADDR_W-1:0]            bus_addr,
  output logic [1:0]                   bus_size,
  input  logic                         bus_rvalid,
  input  logic [31:0]                  bus_rdata
);
  localparam int LINE_W  = ADDR_W - OFS_W;
  localparam int IDX_TOP = SPLIT_IDX ? 11 : 12;
  localparam int IDX_W   = IDX_TOP - OFS_W + 1;

  function automatic logic [IDX_W-1:0] idx_of(input logic [LINE_W-1:0] line);
    return line[IDX_W-1:0];
  endfunction

  // Named internal events, observed by the bound checker.
  path_e                 path;
  bsize_e                one_size, seq_size;
  seq_e                  st;
  logic [LINE_W-1:0]     fch_line, lfb_line;
  logic [WSEL_W-1:0]     fch_word, beat_word;
  logic                  lfb_mru, lfb_nc, lfb_loaded, lfb_full;
  logic [LINE_WORDS-1:0] lfb_vld;
  logic                  buf_hit;
  logic [DATA_W-1:0]     buf_word;
  logic                  beat_we, beat_first, single_done;
  logic                  seq_idle, seq_line, use_buf, ary_ok, buf_ok;
  logic                  pick_buf, pick_ary;
  logic                  serve_buf, serve_ary, miss_take, single_take, bus_done;
  logic                  mru_clr, commit_ok;
  src_e                  src;

  assign fch_line = fch_addr[ADDR_W-1:OFS_W];
  assign fch_word = fch_addr[OFS_W-1:2];

  ifill_path_dec u_dec (
    .cache_en (cfg_cache_en),
    .buf_en   (cfg_buf_en),
    .cacheable(fch_cacheable),
    .half_sel (fch_addr[1]),
    .path     (path),
    .one_size (one_size)
  );

  ifill_buf_store #(.LINE_W(LINE_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (miss_take),
    .load_line  (fch_line),
    .load_nc    (path == PATH_BUFONLY),
    .beat_we    (beat_we),
    .beat_word  (beat_word),
    .beat_data  (bus_rdata),
    .mru_clr    (mru_clr),
    .look_line  (fch_line),
    .look_word  (fch_word),
    .look_hit   (buf_hit),
    .look_data  (buf_word),
    .held_line  (lfb_line),
    .held_mru   (lfb_mru),
    .held_nc    (lfb_nc),
    .held_loaded(lfb_loaded),
    .held_full  (lfb_full),
    .held_vld   (lfb_vld),
    .held_flat  (ary_wdata)
  );

  ifill_bus_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_line    (miss_take),
    .go_single  (single_take),
    .go_addr    (fch_addr),
    .go_size    (one_size),
    .bus_rvalid (bus_rvalid),
    .st         (st),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .bus_size   (seq_size),
    .beat_we    (beat_we),
    .beat_word  (beat_word),
    .beat_first (beat_first),
    .single_done(single_done)
  );

  assign seq_idle = (st == ST_IDLE);
  assign seq_line = (st == ST_LINE);

  // Source selection: the buffer wins while it is the newer copy.
  assign use_buf   = (path != PATH_DIRECT);
  assign ary_ok    = (path == PATH_CACHE) && ary_hit;
  assign buf_ok    = use_buf && buf_hit;
  assign pick_buf  = buf_ok && (lfb_mru || !ary_ok);
  assign pick_ary  = ary_ok && !pick_buf;

  assign serve_buf   = fch_valid && (seq_idle || seq_line) && pick_buf;
  assign serve_ary   = fch_valid && seq_idle && pick_ary;
  assign miss_take   = fch_valid && seq_idle && use_buf && !pick_buf && !pick_ary;
  assign single_take = fch_valid && seq_idle && !use_buf;
  assign bus_done    = fch_valid && (beat_first || single_done);

  assign mru_clr   = serve_ary && lfb_loaded && (idx_of(fch_line) == idx_of(lfb_line));
  assign commit_ok = lfb_loaded && lfb_full && lfb_mru && !lfb_nc;

  assign ary_we    = miss_take && commit_ok;
  assign ary_wline = lfb_line;
  assign bus_size  = seq_size;
  assign fch_ready = bus_done || serve_buf || serve_ary;

  always_comb begin
    fch_rdata = ary_rdata;
    src       = SRC_ARRAY;
    if (bus_done) begin
      fch_rdata = bus_rdata;
      src       = SRC_BUS;
    end else if (serve_buf) begin
      fch_rdata = buf_word;
      src       = SRC_BUF;
    end
  end
  assign fch_src = src;
endmodule

// File: rtl/ifill_ctrl_chk.sv
module ifill_ctrl_chk
  import ifill_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_cache_en,
  input logic                  fch_valid,
  input logic                  fch_ready,
  input logic [1:0]            fch_src,
  input logic                  bus_req,
  input logic [1:0]            bus_size,
  input logic                  bus_half,
  input logic                  ary_we,
  input logic                  lfb_full,
  input logic                  lfb_mru,
  input logic                  lfb_nc,
  input logic [LINE_WORDS-1:0] lfb_vld,
  input logic                  miss_take
);
  // R3 and R9: only a complete, newer, cacheable line goes to the array.
  p_commit_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ary_we |-> (lfb_full && lfb_mru && !lfb_nc));

  p_miss_marks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    miss_take |=> (lfb_mru && lfb_vld == '0 && bus_req && bus_size == 2'd2));

  p_req_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req);

  p_off_no_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !cfg_cache_en) |-> (bus_size != 2'd2));

  p_half_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_size == 2'd0) |-> bus_half);

  p_buf_src_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_ready && fch_src == 2'd2) |-> (lfb_vld != '0));

  p_ready_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fch_ready |-> fch_valid);
endmodule

bind ifetch_fill_ctrl ifill_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_cache_en(cfg_cache_en),
  .fch_valid   (fch_valid),
  .fch_ready   (fch_ready),
  .fch_src     (fch_src),
  .bus_req     (bus_req),
  .bus_size    (bus_size),
  .bus_half    (bus_addr[1]),
  .ary_we      (ary_we),
  .lfb_full    (lfb_full),
  .lfb_mru     (lfb_mru),
  .lfb_nc      (lfb_nc),
  .lfb_vld     (lfb_vld),
  .miss_take   (miss_take)
);

// File: tb/ifetch_fill_ctrl_bench.sv
module ifetch_fill_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 32;
  localparam int LAT        = 2;
  localparam int NV         = 18;

  logic          clk, rst_n;
  logic          cfg_cache_en, cfg_buf_en, fch_valid, fch_cacheable;
  logic [AW-1:0] fch_addr;
  logic          fch_ready;
  logic [31:0]   fch_rdata;
  logic [1:0]    fch_src;
  logic          ary_hit;
  logic [31:0]   ary_rdata;
  logic          ary_we;
  logic [AW-5:0] ary_wline;
  logic [127:0]  ary_wdata;
  logic          bus_req;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic          bus_rvalid;
  logic [31:0]   bus_rdata;

  ifetch_fill_ctrl #(.ADDR_W(AW), .SPLIT_IDX(1'b0)) u_ifetch_fill_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_cache_en(cfg_cache_en), .cfg_buf_en(cfg_buf_en),
    .fch_valid(fch_valid), .fch_addr(fch_addr), .fch_cacheable(fch_cacheable),
    .fch_ready(fch_ready), .fch_rdata(fch_rdata), .fch_src(fch_src),
    .ary_hit(ary_hit), .ary_rdata(ary_rdata), .ary_we(ary_we),
    .ary_wline(ary_wline), .ary_wdata(ary_wdata), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC0DE_0000;
  endfunction
  function automatic logic [31:0] apat(input logic [31:0] a);
    return a ^ 32'h0A0A_0000;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bus responder: wrapping line bursts or single beats after LAT cycles.
  logic [1:0]  seen_size;
  logic [31:0] seen_addr;
  initial begin
    bus_rvalid = 1'b0;
    bus_rdata  = '0;
    seen_size  = '0;
    seen_addr  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && bus_req) begin
        seen_size = bus_size;
        seen_addr = bus_addr;
        repeat (LAT) @(negedge clk);
        for (int k = 0; k < ((seen_size == 2'd2) ? 4 : 1); k++) begin
          bus_rvalid = 1'b1;
          bus_rdata  = (seen_size == 2'd2)
                     ? pat({seen_addr[31:4], 2'(seen_addr[3:2] + k), 2'b00})
                     : pat(seen_addr);
          @(negedge clk);
        end
        bus_rvalid = 1'b0;
      end
    end
  end

  task automatic fetch(input logic cen, input logic ben, input logic cach, input logic ahit,
                       input logic [31:0] addr, output logic [31:0] data,
                       output logic [1:0] src, output logic we, output logic [27:0] wl,
                       output logic [127:0] wd, output int cyc);
    cfg_cache_en = cen; cfg_buf_en = ben; fch_cacheable = cach;
    ary_hit = ahit; ary_rdata = apat(addr);
    fch_addr = addr; fch_valid = 1'b1;
    we = 1'b0; wl = '0; wd = '0; data = '0; src = 2'd3; cyc = 0;
    #1;
    forever begin
      if (ary_we) begin
        we = 1'b1; wl = ary_wline; wd = ary_wdata;
      end
      if (fch_ready) begin
        data = fch_rdata; src = fch_src;
        break;
      end
      cyc++;
      if (cyc > 200) begin
        total++; bad++;
        $display("FAIL R8 no ready for %0h actual=0 expected=1", addr);
        break;
      end
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    fch_valid = 1'b0;
  endtask

  typedef struct packed {
    logic        cen, ben, cach, ahit;
    logic [31:0] addr;
    logic [1:0]  src;
    logic [1:0]  sz;
    logic        we;
    logic [27:0] wl;
    logic        lat;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,1'b1,32'h0000_0100,2'd0,2'd1,1'b0,28'h0,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,32'h0000_0106,2'd0,2'd0,1'b0,28'h0,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,32'h0000_0200,2'd0,2'd2,1'b0,28'h0,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,32'h0000_0208,2'd2,2'd0,1'b0,28'h0,1'b0},
    '{1'b1,1'b1,1'b1,1'b1,32'h0000_0204,2'd2,2'd0,1'b0,28'h0,1'b0},
    '{1'b1,1'b1,1'b1,1'b1,32'h0000_2200,2'd1,2'd0,1'b0,28'h0,1'b0},
    '{1'b1,1'b1,1'b1,1'b1,32'h0000_020C,2'd1,2'd0,1'b0,28'h0,1'b0},
    '{1'b1,1'b1,1'b1,1'b0,32'h0000_0300,2'd0,2'd2,1'b0,28'h0,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,32'h0000_040C,2'd0,2'd2,1'b1,28'h30,1'b0},
    '{1'b1,1'b1,1'b1,1'b0,32'h0000_0404,2'd2,2'd0,1'b0,28'h0,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,32'h0000_0500,2'd0,2'd2,1'b1,28'h40,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,32'h0000_0508,2'd2,2'd0,1'b0,28'h0,1'b0},
    '{1'b1,1'b1,1'b1,1'b0,32'h0000_0600,2'd0,2'd2,1'b0,28'h0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,32'h0000_0608,2'd0,2'd1,1'b0,28'h0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,32'h0000_060A,2'd0,2'd0,1'b0,28'h0,1'b0},
    '{1'b1,1'b0,1'b1,1'b0,32'h0000_0608,2'd2,2'd0,1'b0,28'h0,1'b0},
    '{1'b1,1'b1,1'b1,1'b1,32'h0000_0700,2'd1,2'd0,1'b0,28'h0,1'b0},
    '{1'b1,1'b1,1'b1,1'b0,32'h0000_0800,2'd0,2'd2,1'b1,28'h60,1'b1}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R4";   1: return "R7";   2: return "R1";   3: return "R8";
      4: return "R10";  5: return "R2";   6: return "R10";  7: return "R3";
      8: return "R3";   9: return "R1";  10: return "R6";  11: return "R6";
      12: return "R9"; 13: return "R5";  14: return "R5";  15: return "R8";
      16: return "R2"; default: return "R3";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0]  d;
    logic [1:0]   s;
    logic         w;
    logic [27:0]  l;
    logic [127:0] wd;
    logic [127:0] exp_wd;
    int           c;
    vec_t         v;

    rst_n = 1'b0; cfg_cache_en = 1'b0; cfg_buf_en = 1'b0; fch_valid = 1'b0;
    fch_addr = '0; fch_cacheable = 1'b0; ary_hit = 1'b0; ary_rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R12", "bus_req in reset", 128'(bus_req), 128'(0));
    chk("R12", "ary_we in reset", 128'(ary_we), 128'(0));
    chk("R12", "fch_ready in reset", 128'(fch_ready), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      fetch(v.cen, v.ben, v.cach, v.ahit, v.addr, d, s, w, l, wd, c);
      chk("R11", $sformatf("src of %0h (%s)", v.addr, vtag(i)), 128'(s), 128'(v.src));
      chk(vtag(i), $sformatf("data of %0h", v.addr), 128'(d),
          128'((v.src == 2'd1) ? apat(v.addr) : pat(v.addr)));
      chk(vtag(i), $sformatf("array write at %0h", v.addr), 128'(w), 128'(v.we));
      if (v.we) begin
        for (int k = 0; k < 4; k++)
          exp_wd[k*32 +: 32] = pat({v.wl, 2'(k), 2'b00});
        chk(vtag(i), "written line address", 128'(l), 128'(v.wl));
        chk(vtag(i), "written line data", wd, exp_wd);
      end
      if (v.src == 2'd0) begin
        chk((v.sz == 2'd2) ? "R1" : "R7", $sformatf("bus size for %0h", v.addr),
            128'(seen_size), 128'(v.sz));
        if (v.sz == 2'd2)
          chk("R1", "critical longword address", 128'(seen_addr), 128'({v.addr[31:2], 2'b00}));
      end
      if (v.lat)
        chk("R8", $sformatf("cycles to data for %0h", v.addr), 128'(c), 128'(1 + LAT));
    end

    repeat (8) @(negedge clk);
    #1;
    chk("R1", "bus idle after traffic", 128'(bus_req), 128'(0));
    chk("R11", "no ready without fetch", 128'(fch_ready), 128'(0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule